// File: doc/BRIEF.md
# Bit-level serial EEPROM responder

This block answers a two-wire serial bus at the pin level, one sample at a time. The host bit-bangs the clock and data lines and raises a one-cycle update strobe each time it presents a new pair of line levels. The block keeps the previous pair and compares the two. From that comparison it recognises bus start and stop conditions and valid data bits. It shifts in a command byte and then an address byte, and it pulls the data line low in an acknowledge slot after each of them.

When the address byte is complete, the block fetches the addressed byte from a fixed 256-byte table into an output shift register. That byte is not sent straight away. It leaves the block, most significant bit first, during the address phase of the next transaction whose command byte ends in a 1. The data line the host reads back is the last registered data level. That level is the host's own value, unless the block drove the line for an acknowledge or a data bit.

Top module: `serial_rom_responder`

## Requirements
- R1: While the synchronous reset `rst` is high, the bit counter and the acknowledge flag are cleared, both stored line levels are set to 1, and `sdaOut` reads 1.
- R2: When `pinStrobe` is low, no state changes and `sdaOut` holds its value, whatever the line inputs do.
- R3: A strobe with the stored clock level 1, `sclIn` = 1, and the data line going from 1 to 0 is a start condition. It sets the bit counter to 1 and clears the command byte, even when a byte is only partly received. A data rise while the clock stays high is a stop condition and changes nothing else.
- R4: While the bit counter is 0 and no acknowledge is pending, every strobe other than a start only copies the line levels: `sdaOut` follows `sdaIn` and no acknowledge is ever driven.
- R5: A data bit is taken only on a strobe where the clock rises (stored 0, `sclIn` 1) and `sdaIn` equals the stored data level. A clock rise that arrives together with a data change is not counted.
- R6: The first 8 valid bits after a start form the command byte, shifted in MSB first. On the next clock rise the block drives `sdaOut` to 0 for that one slot.
- R7: The next 8 valid bits form the address, MSB first. If the command byte's bit 0 is 0, `sdaOut` follows the host's data level during these bits.
- R8: If the command byte's bit 0 is 1, each address-bit clock rise puts the MSB of the output shift register on `sdaOut`, and the register then shifts left one place. This sends the previously fetched byte MSB first.
- R9: After the 8th address bit, the table byte at that address is loaded into the output shift register. The next clock rise is acknowledged with `sdaOut` = 0, and the block then returns to idle until a new start.
- R10: The table holds 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01, 0x40, 0x00 at addresses 0x00 to 0x07, 0x64 at 0x7E and 0xF4 at 0x7F, and zero at every other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pinStrobe | input | 1 | High for one cycle when a new line-level pair is presented |
| sclIn | input | 1 | Clock line level from the host |
| sdaIn | input | 1 | Data line level from the host |
| sdaOut | output | 1 | Registered data line level as seen by the host |

## Verification
The hardest case to reach from the ports is a clock rise that comes with a data change in the middle of a command byte. It is also hard to show that such a rise was dropped, because its only trace is when the acknowledge appears later. The bench sends three command bits, then a low-clock sample at 0 followed by a rising-clock sample at 1, then the last five bits. It checks that the eighth real bit still reads back as the host's level and that the acknowledge comes in the slot after it. A restart after half a byte is reached the same way: the bench checks where the acknowledge falls. Read data can only be seen one transaction after it is fetched, so the vector table chains addresses and each row checks the byte fetched by the row before.

// File: rtl/srr_pkg.sv
package srr_pkg;

  // Width of command, address and data bytes
  localparam int BYTE_W = 8;
  // Counter must reach 2*BYTE_W+1 before wrapping
  localparam int TICK_W = $clog2(2 * BYTE_W + 2);
  // Counter value at which the command byte is complete
  localparam logic [TICK_W-1:0] CMD_DONE  = TICK_W'(BYTE_W + 1);
  // Counter value at which the address byte is complete
  localparam logic [TICK_W-1:0] ADDR_DONE = TICK_W'(2 * BYTE_W + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // store the new line levels
    logic clrCmd;    // start condition: empty command byte
    logic shiftCmd;  // take a command bit
    logic shiftAddr; // take an address bit, shift output register
    logic driveAck;  // force data line low this slot
    logic driveData; // put output register MSB on data line
    logic loadData;  // fetch table byte at completed address
  } dpCtl_t;

  // Fixed table contents, computed per address
  function automatic logic [BYTE_W-1:0] romByte(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] v;
    case (a)
      8'h00:   v = 8'h80;
      8'h01:   v = 8'h08;
      8'h02:   v = 8'h04;
      8'h03:   v = 8'h0D;
      8'h04:   v = 8'h0A;
      8'h05:   v = 8'h01;
      8'h06:   v = 8'h40;
      8'h7E:   v = 8'h64;
      8'h7F:   v = 8'hF4;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pinStrobe,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              sclHeld,
  input  logic              sdaHeld,
  input  logic              cmdLsb,
  output dpCtl_t            ctl,
  output logic [TICK_W-1:0] tickCount,
  output logic              ackPending
);

  logic [TICK_W-1:0] tickNext;
  logic [TICK_W-1:0] tickInc;
  logic              ackNext;
  logic              levelChange;
  logic              sclRise;
  logic              idle;

  assign tickInc     = tickCount + TICK_W'(1);
  assign levelChange = sclHeld & sclIn & (sdaHeld ^ sdaIn);
  assign sclRise     = ~sclHeld & sclIn;
  assign idle        = (tickCount == '0) && !ackPending;

  always_comb begin
    ctl      = '0;
    tickNext = tickCount;
    ackNext  = ackPending;
    if (pinStrobe) begin
      ctl.capture = 1'b1;
      if (levelChange) begin
        // data moved under a high clock: start when falling, stop otherwise
        if (!sdaIn) begin
          tickNext   = TICK_W'(1);
          ctl.clrCmd = 1'b1;
        end
      end else if (!idle && sclRise) begin
        if (ackPending) begin
          ctl.driveAck = 1'b1;
          ackNext      = 1'b0;
        end else if (sdaHeld == sdaIn) begin
          if (tickCount < CMD_DONE) begin
            ctl.shiftCmd = 1'b1;
            tickNext     = tickInc;
            if (tickInc == CMD_DONE) ackNext = 1'b1;
          end else begin
            ctl.shiftAddr = 1'b1;
            ctl.driveData = cmdLsb;
            if (tickInc == ADDR_DONE) begin
              ctl.loadData = 1'b1;
              ackNext      = 1'b1;
              tickNext     = '0;
            end else begin
              tickNext = tickInc;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCount  <= '0;
      ackPending <= 1'b0;
    end else begin
      tickCount  <= tickNext;
      ackPending <= ackNext;
    end
  end

endmodule

// File: rtl/srr_datapath.sv
module srr_datapath
  import srr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  dpCtl_t ctl,
  output logic   sclHeld,
  output logic   sdaHeld,
  output logic   cmdLsb
);

  logic [BYTE_W-1:0] cmdReg;
  logic [BYTE_W-1:0] addrReg;
  logic [BYTE_W-1:0] dataSr;
  logic [BYTE_W-1:0] addrNext;
  logic              sdaNext;

  assign addrNext = (addrReg << 1) | BYTE_W'(sdaIn);
  assign cmdLsb   = cmdReg[0];

  always_comb begin
    if (ctl.driveAck)       sdaNext = 1'b0;
    else if (ctl.driveData) sdaNext = dataSr[BYTE_W-1];
    else                    sdaNext = sdaIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclHeld <= 1'b1;
      sdaHeld <= 1'b1;
      cmdReg  <= '0;
      addrReg <= '0;
      dataSr  <= '0;
    end else begin
      if (ctl.capture) begin
        sclHeld <= sclIn;
        sdaHeld <= sdaNext;
      end
      if (ctl.clrCmd)        cmdReg <= '0;
      else if (ctl.shiftCmd) cmdReg <= (cmdReg << 1) | BYTE_W'(sdaIn);
      if (ctl.shiftAddr)     addrReg <= addrNext;
      if (ctl.loadData)      dataSr <= romByte(addrNext);
      else if (ctl.shiftAddr) dataSr <= dataSr << 1;
    end
  end

endmodule

// File: rtl/serial_rom_responder.sv
module serial_rom_responder
  import srr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pinStrobe,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOut
);

  dpCtl_t            ctl;
  logic [TICK_W-1:0] tickCount;
  logic              ackPending;
  logic              sclHeld;
  logic              sdaHeld;
  logic              cmdLsb;

  srr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pinStrobe  (pinStrobe),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .sclHeld    (sclHeld),
    .sdaHeld    (sdaHeld),
    .cmdLsb     (cmdLsb),
    .ctl        (ctl),
    .tickCount  (tickCount),
    .ackPending (ackPending)
  );

  srr_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .ctl     (ctl),
    .sclHeld (sclHeld),
    .sdaHeld (sdaHeld),
    .cmdLsb  (cmdLsb)
  );

  assign sdaOut = sdaHeld;

endmodule

// File: rtl/srr_checker.sv
module srr_checker
  import srr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pinStrobe,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sdaOut,
  input logic              sclHeld,
  input logic [TICK_W-1:0] tickCount,
  input logic              ackPending
);

  // R1: reset leaves the block idle with the data line released
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (sdaOut && tickCount == '0 && !ackPending));

  // R2: no strobe, no change
  p_hold_nostrobe_r2: assert property (@(posedge clk) disable iff (rst)
    !pinStrobe |=> ($stable(sdaOut) && $stable(tickCount) && $stable(ackPending)));

  // R3: start condition restarts the counter
  p_start_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (pinStrobe && sclHeld && sclIn && sdaOut && !sdaIn) |=> (tickCount == TICK_W'(1)));

  // R4: idle only mirrors the host data level
  p_idle_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    (pinStrobe && tickCount == '0 && !ackPending) |=> (sdaOut == $past(sdaIn)));

  // R5: a clock rise with a data change is not a bit
  p_glitch_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (pinStrobe && !ackPending && !sclHeld && sclIn && (sdaIn != sdaOut)) |=> $stable(tickCount));

  // R6: a pending acknowledge is driven low on the next clock rise
  p_ack_slot_r6: assert property (@(posedge clk) disable iff (rst)
    (pinStrobe && ackPending && !sclHeld && sclIn) |=> (!sdaOut && !ackPending));

  // R9: counter wraps to zero before reaching the address-complete value
  p_tick_bound_r9: assert property (@(posedge clk) disable iff (rst)
    tickCount < ADDR_DONE);

endmodule

bind serial_rom_responder srr_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .pinStrobe  (pinStrobe),
  .sclIn      (sclIn),
  .sdaIn      (sdaIn),
  .sdaOut     (sdaOut),
  .sclHeld    (sclHeld),
  .tickCount  (tickCount),
  .ackPending (ackPending)
);

// File: tb/sim_serial_rom_responder.sv
`timescale 1ns/1ps
module sim_serial_rom_responder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pinStrobe = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic sdaOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_rom_responder u0 (
    .clk       (clk),
    .rst       (rst),
    .pinStrobe (pinStrobe),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sdaOut    (sdaOut)
  );

  // {command, address, expected sdaOut byte during address phase}
  // write rows (command bit0 = 0) expect the address itself (R7)
  // read rows expect the byte fetched by the previous row (R8, R10)
  localparam logic [23:0] VEC [0:9] = '{
    24'hA0_03_03,  // write, fetch 0x0D
    24'hA1_7E_0D,  // read 0x0D, fetch 0x64
    24'hA1_00_64,  // read 0x64, fetch 0x80
    24'hA1_7F_80,  // read 0x80, fetch 0xF4
    24'hA1_55_F4,  // read 0xF4, fetch 0x00
    24'hA1_05_00,  // read 0x00, fetch 0x01
    24'hA0_06_06,  // write, fetch 0x40
    24'hA1_01_40,  // read 0x40, fetch 0x08
    24'hA1_02_08,  // read 0x08, fetch 0x04
    24'hA1_00_04   // read 0x04, fetch 0x80
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic pins(input logic s, input logic d);
    @(negedge clk);
    sclIn = s;
    sdaIn = d;
    pinStrobe = 1'b1;
    @(negedge clk);
    pinStrobe = 1'b0;
  endtask

  task automatic sendBit(input logic b, output logic seen);
    pins(1'b0, b);
    pins(1'b1, b);
    seen = sdaOut;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      sendBit(b[i], s);
      seen[i] = s;
    end
  endtask

  task automatic ackSlot(output logic seen);
    sendBit(1'b1, seen);
  endtask

  task automatic startCond();
    pins(1'b1, 1'b1);
    pins(1'b1, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen;
    logic       ack;
    logic       b;

    repeat (3) @(negedge clk);
    check("R1 reset sdaOut", {7'd0, sdaOut}, 8'h01);
    rst = 1'b0;
    @(negedge clk);

    // R4: clocking without a start is ignored, no acknowledge appears
    sendByte(8'hFF, seen);
    check("R4 idle bits mirrored", seen, 8'hFF);
    ackSlot(ack);
    check("R4 no ack while idle", {7'd0, ack}, 8'h01);

    // table walk
    for (int r = 0; r < 10; r++) begin
      logic [7:0] c, a, e;
      {c, a, e} = VEC[r];
      startCond();
      sendByte(c, seen);
      check("R6 command bits", seen, c);
      ackSlot(ack);
      check("R6 command ack", {7'd0, ack}, 8'h00);
      sendByte(a, seen);
      check(c[0] ? "R8 R10 read data out" : "R7 write addr mirror", seen, e);
      ackSlot(ack);
      check("R9 address ack", {7'd0, ack}, 8'h00);
    end

    // R5: a clock rise together with a data change is dropped
    startCond();
    sendBit(1'b1, b);
    sendBit(1'b0, b);
    sendBit(1'b1, b);
    pins(1'b0, 1'b0);
    pins(1'b1, 1'b1);
    sendBit(1'b0, b);
    sendBit(1'b0, b);
    sendBit(1'b0, b);
    sendBit(1'b0, b);
    sendBit(1'b1, b);
    check("R5 eighth valid bit not acked", {7'd0, b}, 8'h01);
    ackSlot(ack);
    check("R5 ack after eight valid bits", {7'd0, ack}, 8'h00);
    sendByte(8'h7E, seen);
    check("R8 read after glitch", seen, 8'h80);
    ackSlot(ack);
    check("R9 ack after glitch txn", {7'd0, ack}, 8'h00);

    // R3: a start in mid-byte restarts the command byte
    startCond();
    for (int i = 0; i < 4; i++) sendBit(1'b1, b);
    startCond();
    sendByte(8'hA1, seen);
    check("R3 command after restart", seen, 8'hA1);
    ackSlot(ack);
    check("R3 ack timing after restart", {7'd0, ack}, 8'h00);
    sendByte(8'h00, seen);
    check("R3 R10 read 0x7E byte", seen, 8'h64);
    ackSlot(ack);
    check("R9 ack after restart txn", {7'd0, ack}, 8'h00);

    // R2: line changes without a strobe are not taken
    @(negedge clk);
    sclIn = 1'b0;
    sdaIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 no strobe holds sdaOut", {7'd0, sdaOut}, 8'h00);

    // R9: after the address acknowledge the block is idle again
    sendByte(8'h00, seen);
    check("R9 idle after ack mirrors", seen, 8'h00);
    ackSlot(ack);
    check("R9 no ack while idle", {7'd0, ack}, 8'h01);

    // R1: reset in mid-transaction returns to idle
    startCond();
    sendByte(8'hA1, seen);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 sdaOut after reset", {7'd0, sdaOut}, 8'h01);
    ackSlot(ack);
    check("R1 no pending ack after reset", {7'd0, ack}, 8'h01);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule